// File: doc/BRIEF.md
# Eight-Lane Iterative Sine Approximator

This block approximates sin(x) for eight fixed-point inputs at once by summing the odd-power Taylor series term by term. A start pulse captures an eight-lane input vector and a term count. One control sequencer then drives all eight lane datapaths in lock-step, so every lane performs the same operation in each cycle. Each lane first forms x squared and x cubed. It then repeatedly adds or subtracts the current power divided by its odd factorial, and raises the power by x squared for the next term. The division is done by multiplying with a reciprocal constant that is computed when the block is elaborated.

The block is intended as a compute kernel inside a larger data-parallel engine. The caller supplies eight angles, chooses the number of series terms (more terms give more accuracy and take more cycles), and collects the eight results on the one-cycle done pulse. The result vector stays on the output until the next run completes.

Top module: `tsin_top`

## Requirements
- R1: Each lane input and output is a 17-bit two's-complement value with 14 fraction bits (2 integer bits plus sign). Lane k occupies bits [17k+16:17k] of `x_i` and `res_o`. The result of a lane is its 32-bit accumulator clamped to the 17-bit range.
- R2: At setup each lane computes s = sat32(floor(x*x/2^14)) and p = sat32(floor(s*x/2^14)), and sets its accumulator to x.
- R3: The term count is sampled at start. A value of 0 is treated as 1 and a value above 8 as 8. With one term, the result equals the input.
- R4: For term index j = 1 up to count-1, the lane computes t = floor(p*C_j/2^32) with C_j = round(2^32/(2j+1)!). It subtracts t from the accumulator for odd j and adds t for even j, saturating at 32 bits. It then sets p = sat32(floor(p*s/2^14)).
- R5: `done_o` is high for exactly one cycle, in the cycle that follows the (count+2)-th rising edge after the edge that samples start.
- R6: `res_o` changes only on the edge that raises `done_o` and holds its value at all other times, including while a later run is in progress.
- R7: A start pulse that arrives while a run is in progress is ignored: the inputs, the term count and the timing of that run are unaffected.
- R8: The lanes are independent: the result of a lane depends only on its own input and the shared term count.
- R9: Intermediate values saturate at the signed 32-bit limits and outputs at the signed 17-bit limits instead of wrapping (input 0x0FFFF with two terms gives 0x10000, input 0x10000 with two terms gives 0x0FFFF).
- R10: An asynchronous low on `rst_ni` clears `res_o` and `done_o` at once and abandons any run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures `x_i` and `terms_i` when idle |
| terms_i | input | 4 | Number of series terms, clamped to 1..8 |
| x_i | input | 136 | Eight packed lane inputs, 17 bits each |
| res_o | output | 136 | Eight packed lane results, 17 bits each |
| done_o | output | 1 | One-cycle pulse when the results are updated |

## Verification
The lane vectors mix zero, small values, values near ±1, ±π/2, ±π and the extreme codes. Term counts run from 1 to 8. This separates errors in the sign alternation, in the reciprocal constants and in the power recurrence, because each of these shows up first in a different term. Inputs of ±π with eight terms push the power past the 32-bit limit, and the extreme codes with two terms push the sum past the output range, so a wrapping datapath gives visibly different results. Two vectors that differ in a single lane expose any cross-lane leakage. A second start issued mid-run, and a reset issued mid-run, check that an in-progress run can be neither disturbed nor resumed.

// File: rtl/tsin_pkg.sv
package tsin_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SQ, ST_CUBE, ST_ITER} state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_SQ, OP_CUBE, OP_STEP, OP_FIN
  } op_e;

  // round(2^rw / (2j+1)!)
  function automatic longint unsigned inv_odd_fact(input int j, input int rw);
    longint unsigned f;
    f = 64'd1;
    for (int k = 2; k <= 2 * j + 1; k++) f = f * longint'(k);
    return ((64'd1 << rw) + f / 2) / f;
  endfunction

endpackage

// File: rtl/tsin_ctrl.sv
module tsin_ctrl
  import tsin_pkg::*;
#(
  parameter int MAX_TERMS = 8,
  parameter int TERM_W    = 4,
  parameter int RW        = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TERM_W-1:0] terms_i,
  output op_e               op_o,
  output logic              sub_o,
  output logic [RW-1:0]     recip_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [TERM_W-1:0] tcnt_o
);

  localparam int TAB_N = 2 ** TERM_W;

  state_e            state_q;
  logic [TERM_W-1:0] j_q, tcnt_q;
  logic              done_q;
  logic [RW-1:0]     rtab [TAB_N];

  for (genvar g = 0; g < TAB_N; g++) begin : g_rtab
    if (g >= 1 && g < MAX_TERMS) begin : g_val
      assign rtab[g] = RW'(inv_odd_fact(g, RW));
    end else begin : g_zero
      assign rtab[g] = '0;
    end
  end

  function automatic logic [TERM_W-1:0] clamp_terms(input logic [TERM_W-1:0] t);
    if (t == '0) return TERM_W'(1);
    if (t > TERM_W'(MAX_TERMS)) return TERM_W'(MAX_TERMS);
    return t;
  endfunction

  always_comb begin
    op_o = OP_NONE;
    unique case (state_q)
      ST_IDLE: if (start_i) op_o = OP_LOAD;
      ST_SQ:   op_o = OP_SQ;
      ST_CUBE: op_o = OP_CUBE;
      ST_ITER: op_o = (j_q < tcnt_q) ? OP_STEP : OP_FIN;
      default: op_o = OP_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      j_q     <= '0;
      tcnt_q  <= TERM_W'(1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tcnt_q  <= clamp_terms(terms_i);
          state_q <= ST_SQ;
        end
        ST_SQ:   state_q <= ST_CUBE;
        ST_CUBE: begin
          j_q     <= TERM_W'(1);
          state_q <= ST_ITER;
        end
        ST_ITER: begin
          if (j_q < tcnt_q) begin
            j_q <= j_q + TERM_W'(1);
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sub_o   = j_q[0];
  assign recip_o = rtab[j_q];
  assign done_o  = done_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign tcnt_o  = tcnt_q;

endmodule

// File: rtl/tsin_lane.sv
module tsin_lane
  import tsin_pkg::*;
#(
  parameter int DW   = 17,
  parameter int AW   = 32,
  parameter int RW   = 32,
  parameter int FRAC = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic          sub_i,
  input  logic [RW-1:0] recip_i,
  input  logic [DW-1:0] x_i,
  output logic [DW-1:0] res_o
);

  localparam int PW = 2 * AW;
  localparam logic signed [PW-1:0] AMAX = {{(AW+1){1'b0}}, {(AW-1){1'b1}}};
  localparam logic signed [PW-1:0] AMIN = {{(AW+1){1'b1}}, {(AW-1){1'b0}}};
  localparam logic signed [AW-1:0] DMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] DMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW-1:0] x_q, res_q;
  logic signed [AW-1:0] x2_q, num_q, acc_q;
  logic signed [PW-1:0] xe, x2e, nume, acce, rce;
  logic signed [PW-1:0] ma, mb, m0, m0s, m1, term, sum;

  function automatic logic signed [AW-1:0] sat_a(input logic signed [PW-1:0] v);
    if (v > AMAX) return AMAX[AW-1:0];
    if (v < AMIN) return AMIN[AW-1:0];
    return v[AW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] sat_d(input logic signed [AW-1:0] v);
    if (v > DMAX) return DMAX[DW-1:0];
    if (v < DMIN) return DMIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  assign xe   = {{(PW-DW){x_q[DW-1]}}, x_q};
  assign x2e  = {{AW{x2_q[AW-1]}}, x2_q};
  assign nume = {{AW{num_q[AW-1]}}, num_q};
  assign acce = {{AW{acc_q[AW-1]}}, acc_q};
  assign rce  = {{(PW-RW){1'b0}}, recip_i};

  // power multiplier shared by square, cube and power update
  always_comb begin
    ma = xe;
    mb = xe;
    unique case (op_i)
      OP_CUBE: ma = x2e;
      OP_STEP: begin ma = nume; mb = x2e; end
      default: ;
    endcase
  end

  assign m0   = ma * mb;
  assign m0s  = m0 >>> FRAC;
  assign m1   = nume * rce;
  assign term = m1 >>> RW;
  assign sum  = sub_i ? (acce - term) : (acce + term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      x2_q  <= '0;
      num_q <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD: x_q  <= x_i;
        OP_SQ:   x2_q <= sat_a(m0s);
        OP_CUBE: begin
          num_q <= sat_a(m0s);
          acc_q <= xe[AW-1:0];
        end
        OP_STEP: begin
          num_q <= sat_a(m0s);
          acc_q <= sat_a(sum);
        end
        OP_FIN:  res_q <= sat_d(acc_q);
        default: ;
      endcase
    end
  end

  assign res_o = res_q;

endmodule

// File: rtl/tsin_top.sv
module tsin_top
  import tsin_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int DW        = 17,
  parameter int FRAC      = 14,
  parameter int AW        = 32,
  parameter int RW        = 32,
  parameter int MAX_TERMS = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [$clog2(MAX_TERMS+1)-1:0]   terms_i,
  input  logic [LANES*DW-1:0]              x_i,
  output logic [LANES*DW-1:0]              res_o,
  output logic                             done_o
);

  localparam int TERM_W = $clog2(MAX_TERMS + 1);

  op_e               op;
  logic              sub;
  logic [RW-1:0]     recip;
  logic              busy;
  logic [TERM_W-1:0] tcnt;

  tsin_ctrl #(
    .MAX_TERMS(MAX_TERMS),
    .TERM_W   (TERM_W),
    .RW       (RW)
  ) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .terms_i(terms_i),
    .op_o   (op),
    .sub_o  (sub),
    .recip_o(recip),
    .done_o (done_o),
    .busy_o (busy),
    .tcnt_o (tcnt)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tsin_lane #(
      .DW  (DW),
      .AW  (AW),
      .RW  (RW),
      .FRAC(FRAC)
    ) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op),
      .sub_i  (sub),
      .recip_i(recip),
      .x_i    (x_i[l*DW +: DW]),
      .res_o  (res_o[l*DW +: DW])
    );
  end

endmodule

// File: rtl/tsin_chk.sv
module tsin_chk #(
  parameter int LANES     = 8,
  parameter int DW        = 17,
  parameter int TW        = 4,
  parameter int MAX_TERMS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                done_o,
  input logic [LANES*DW-1:0] res_o,
  input logic                busy_i,
  input logic [TW-1:0]       tcnt_i
);

  localparam int CW = TW + 2;

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cyc_q <= '0;
    else if (start_i && !busy_i) cyc_q <= '0;
    else if (busy_i)             cyc_q <= cyc_q + CW'(1);
  end

  // R5: single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5: pulse lands count+2 edges after the start edge
  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_q == CW'(tcnt_i) + CW'(2)));

  // R6: results frozen outside the done cycle
  a_r6_hold_results: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o));

  // R3: clamped count while running
  a_r3_term_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (tcnt_i >= TW'(1) && tcnt_i <= TW'(MAX_TERMS)));

  // R7: start during a run leaves the count alone
  a_r7_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(tcnt_i));

endmodule

bind tsin_top tsin_chk #(
  .LANES    (LANES),
  .DW       (DW),
  .TW       (TERM_W),
  .MAX_TERMS(MAX_TERMS)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .done_o (done_o),
  .res_o  (res_o),
  .busy_i (busy),
  .tcnt_i (tcnt)
);

// File: tb/test_tsin_top.sv
module test_tsin_top;

  localparam int LANES = 8;
  localparam int DW    = 17;
  localparam int TW    = 4;
  localparam int NV    = 6;

  localparam int VX [NV][LANES] = '{
    '{0, 16384, -16384, 8192, -8192, 25736, -25736, 51472},
    '{100, -100, 4000, -4000, 12000, -12000, 30000, -30000},
    '{0, 16384, -16384, 8192, -8192, 25736, -25736, 51472},
    '{1, -1, 2, -2, 16383, -16383, 40000, -40000},
    '{20000, -20000, 45000, -45000, 51472, -51472, 3000, -3000},
    '{7000, -7000, 33000, -33000, 51000, -51000, 18000, -18000}
  };
  localparam int VT [NV] = '{5, 3, 8, 1, 4, 7};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start = 1'b0;
  logic [TW-1:0]     terms = '0;
  logic [LANES*DW-1:0] x_vec = '0;
  logic [LANES*DW-1:0] res;
  logic              done;

  int checks = 0;
  int fails  = 0;
  int got  [LANES];
  int prev [LANES];

  always #5 clk = ~clk;

  tsin_top i_tsin_top (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .start_i(start),
    .terms_i(terms),
    .x_i    (x_vec),
    .res_o  (res),
    .done_o (done)
  );

  function automatic longint sat(input longint v, input int w);
    longint hi, lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint recip(input int j);
    longint f = 1;
    for (int k = 2; k <= 2 * j + 1; k++) f = f * k;
    return ((longint'(1) <<< 32) + f / 2) / f;
  endfunction

  function automatic int eff_terms(input int t);
    if (t == 0) return 1;
    if (t > 8) return 8;
    return t;
  endfunction

  function automatic int model(input int x, input int t);
    longint xs, x2, num, acc, tm;
    xs  = x;
    x2  = sat((xs * xs) >>> 14, 32);
    num = sat((x2 * xs) >>> 14, 32);
    acc = xs;
    for (int j = 1; j < eff_terms(t); j++) begin
      tm  = (num * recip(j)) >>> 32;
      acc = (j % 2 == 1) ? sat(acc - tm, 32) : sat(acc + tm, 32);
      num = sat((num * x2) >>> 14, 32);
    end
    return int'(sat(acc, 17));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic grab();
    for (int l = 0; l < LANES; l++) got[l] = int'($signed(res[l*DW +: DW]));
  endtask

  task automatic drive(input int xs[LANES], input int t);
    for (int l = 0; l < LANES; l++) x_vec[l*DW +: DW] = DW'(xs[l]);
    terms = TW'(t);
    start = 1'b1;
  endtask

  // lat = number of edges after the start edge until done is seen
  task automatic run(input int xs[LANES], input int t, output int lat);
    @(negedge clk);
    drive(xs, t);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic full_check(input int xs[LANES], input int t, input string req);
    int lat;
    run(xs, t, lat);
    check(lat == eff_terms(t) + 2, "R5", {req, " latency"}, lat, eff_terms(t) + 2);
    grab();
    for (int l = 0; l < LANES; l++)
      check(got[l] == model(xs[l], t), req, $sformatf("lane %0d", l), got[l], model(xs[l], t));
    @(negedge clk);
    check(done == 1'b0, "R5", "done one cycle", done, 0);
    for (int l = 0; l < LANES; l++) prev[l] = got[l];
    repeat (3) @(negedge clk);
    grab();
    for (int l = 0; l < LANES; l++)
      check(got[l] == prev[l], "R6", $sformatf("hold lane %0d", l), got[l], prev[l]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int xa[LANES];
    int xb[LANES];
    int lat;
    int seen;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(res == '0, "R10", "reset res", res, 0);
    check(done == 1'b0, "R10", "reset done", done, 0);
    rst_ni = 1'b1;

    // R1 R2 R4: table walk
    for (int v = 0; v < NV; v++) full_check(VX[v], VT[v], "R4");

    // R3: clamping, one term returns the input
    xa = '{5000, -5000, 16384, -16384, 51472, -51472, 1, 0};
    full_check(xa, 0, "R3");
    for (int l = 0; l < LANES; l++)
      check(got[l] == xa[l], "R3", "one term equals x", got[l], xa[l]);
    full_check(xa, 12, "R3");

    // R9: output and intermediate saturation
    xa = '{65535, -65536, 51472, -51472, 60000, -60000, 0, 16384};
    full_check(xa, 2, "R9");
    check(got[0] == -65536, "R9", "low clamp", got[0], -65536);
    check(got[1] == 65535, "R9", "high clamp", got[1], 65535);
    full_check(xa, 8, "R9");

    // R8: change a single lane, others unchanged
    xa = '{3000, 9000, -12000, 20000, -25000, 30000, -40000, 50000};
    full_check(xa, 6, "R8");
    for (int l = 0; l < LANES; l++) prev[l] = got[l];
    xb = xa;
    xb[3] = -47000;
    run(xb, 6, lat);
    grab();
    for (int l = 0; l < LANES; l++)
      if (l != 3) check(got[l] == prev[l], "R8", $sformatf("lane %0d untouched", l), got[l], prev[l]);
    check(got[3] == model(-47000, 6), "R8", "changed lane", got[3], model(-47000, 6));
    for (int l = 0; l < LANES; l++) prev[l] = got[l];

    // R6: results held while a new run is in progress
    @(negedge clk);
    drive(xa, 8);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    grab();
    for (int l = 0; l < LANES; l++)
      check(got[l] == prev[l], "R6", $sformatf("mid-run lane %0d", l), got[l], prev[l]);
    while (!done) @(negedge clk);

    // R7: start during a run is ignored
    xa = '{11000, -11000, 22000, -22000, 33000, -33000, 44000, -44000};
    xb = '{1, 2, 3, 4, 5, 6, 7, 8};
    @(negedge clk);
    drive(xa, 5);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    @(negedge clk);
    lat++;
    drive(xb, 1);
    @(negedge clk);
    lat++;
    start = 1'b0;
    x_vec = '0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 7, "R7", "latency of first run", lat, 7);
    grab();
    for (int l = 0; l < LANES; l++)
      check(got[l] == model(xa[l], 5), "R7", $sformatf("lane %0d", l), got[l], model(xa[l], 5));
    seen = 0;
    repeat (15) begin
      @(negedge clk);
      if (done) seen++;
    end
    check(seen == 0, "R7", "no second done", seen, 0);

    // R10: asynchronous reset mid-run
    @(negedge clk);
    drive(xa, 8);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(res == '0, "R10", "async clear res", res, 0);
    check(done == 1'b0, "R10", "async clear done", done, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    seen = 0;
    repeat (15) begin
      @(negedge clk);
      if (done) seen++;
    end
    check(seen == 0, "R10", "abandoned run silent", seen, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule